// File: doc/BRIEF.md
# Handshaked Periodic Interrupt Timer

This block is an interval timer for a processor's time-slice interrupt. After reset it counts clock cycles up to one period, which by default is 10 ms at the configured clock frequency. When the period has elapsed it raises a level interrupt line. The line stays high, and counting stays frozen, until the processor acknowledges by flipping the level of its toggle input. The acknowledge clears the line and starts a fresh period from zero.

Either direction of change on the toggle input counts as an acknowledge. The processor therefore only has to invert the bit it last wrote. A toggle that arrives while no interrupt is pending also restarts the period. Because the count does not run on while the interrupt is pending, every interrupt is followed by a full period after its acknowledge, and periods never pile up.

Top module: `tick_irq_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `irq_o` is 0 after that edge.
- R2: After reset is released, `irq_o` goes to 1 exactly PERIOD_CYCLES rising edges after the last edge with `rst_n` low, and not earlier. With the default parameters, PERIOD_CYCLES = CLK_FREQ_HZ / 1_000_000 * PERIOD_US.
- R3: Once high, `irq_o` stays high for as long as `ack_toggle_i` keeps its level, with no time limit.
- R4: A change in level of `ack_toggle_i`, seen at a rising edge, drives `irq_o` to 0 after that edge. `irq_o` then rises again exactly PERIOD_CYCLES edges later.
- R5: Counting is suspended while `irq_o` is high. After any length of pending time, the next interrupt still needs a full PERIOD_CYCLES edges from the acknowledge.
- R6: A toggle while `irq_o` is low restarts the period. `irq_o` then rises PERIOD_CYCLES edges after the toggle edge.
- R7: A rising edge of `ack_toggle_i` (0 to 1) and a falling edge (1 to 0) both act as an acknowledge.
- R8: The level that `ack_toggle_i` holds during reset is sampled as the reference level. Holding that level after release is not seen as a toggle.
- R9: A toggle that lands on the same edge as the end of the period wins. `irq_o` stays low and a fresh period starts.
- R10: Asserting reset while an interrupt is pending clears `irq_o` and restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_toggle_i | input | 1 | Processor acknowledge; every change of level is one acknowledge |
| irq_o | output | 1 | Level interrupt; high when a period has elapsed and is not yet acknowledged |

## Verification
Internal faults in this block show up only as a shift in when `irq_o` rises or falls. An off-by-one in the counter terminal, or a count that keeps running while the interrupt is pending, moves the next rising edge by one or more cycles. The bench therefore samples `irq_o` one edge before and exactly at each expected rise. A lost or spurious toggle detection, for example a reference level that is not sampled in reset, or one edge direction that is ignored, either leaves the line stuck high or delays the rise by one cycle. Each of these is visible within a single period.

// File: rtl/tick_timer_pkg.sv
// Package: shared helpers for the handshaked interval timer.
// Assumes: frequencies are whole multiples of 1 MHz when converted.
package tick_timer_pkg;

    // Convert a period in microseconds into clock cycles.
    function automatic int unsigned us_to_cycles(input int unsigned freq_hz,
                                                 input int unsigned period_us);
        return (freq_hz / 1_000_000) * period_us;
    endfunction

    // Counter width able to hold values 0 .. cycles-1 (at least one bit).
    function automatic int unsigned count_width(input int unsigned cycles);
        return (cycles <= 2) ? 1 : $clog2(cycles);
    endfunction

endpackage

// File: rtl/tick_ack_detect.sv
// Module: detects any change of level on the acknowledge input.
// Assumes: ack_i is synchronous to clk. In reset the stored reference
// takes the current level, so the level held through reset is no toggle.
module tick_ack_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic toggle_o
);
    logic ack_q;

    // Keep the level seen at the previous edge; sample a fresh one in reset.
    always_ff @(posedge clk) begin
        ack_q <= ack_i;
    end

    // A toggle is any difference from the stored level, outside reset.
    always_comb begin
        toggle_o = rst_n && (ack_i != ack_q);
    end

    // R8: after a reset edge, the stored level matches the pin level.
    a_r8_ref_sampled: assert property (@(posedge clk)
        !rst_n |=> (ack_q == $past(ack_i)))
        else $error("reference level not sampled in reset");
endmodule

// File: rtl/tick_period_counter.sv
// Module: cycle counter for one timer period.
// Assumes: PERIOD_CYCLES >= 2. restart has priority over hold, and hold
// has priority over counting. terminal_o pulses on the edge where the
// count completes.
module tick_period_counter #(
    parameter int unsigned PERIOD_CYCLES = 16,
    parameter int unsigned CNT_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] count_o,
    output logic             terminal_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // The period ends when the last count is reached while running.
    always_comb begin
        terminal_o = !restart_i && !hold_i && (cnt_q == LAST);
    end

    // Advance, freeze or clear the cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || terminal_o) begin
            cnt_q <= '0;
        end else if (!hold_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    // R5: a held counter does not move.
    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !restart_i) |=> $stable(cnt_q))
        else $error("counter moved while held");
    // R2: the count never passes the last value.
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST)
        else $error("counter out of range");
endmodule

// File: rtl/tick_irq_latch.sv
// Module: sticky interrupt flag.
// Assumes: set_i and clear_i come from the counter and the toggle
// detector. Clear wins over set on the same edge.
module tick_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic irq_o
);
    logic irq_q;

    // Hold the pending flag until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            irq_q <= 1'b0;
        end else if (set_i) begin
            irq_q <= 1'b1;
        end
    end

    assign irq_o = irq_q;

    // R1: reset leaves the line low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !irq_q)
        else $error("irq high after reset edge");
    // R3: a pending flag stays set without a clear.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clear_i) |=> irq_q)
        else $error("irq dropped without acknowledge");
    // R4: a clear always drops the line.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !irq_q)
        else $error("irq not cleared by acknowledge");
endmodule

// File: rtl/tick_irq_timer.sv
// Module: handshaked periodic interrupt timer (top).
// Counts one period, raises irq_o, freezes, and waits for a level change
// on ack_toggle_i before the next period starts.
// Assumes: synchronous active-low reset; ack_toggle_i synchronous to clk.
module tick_irq_timer #(
    parameter int unsigned CLK_FREQ_HZ   = 100_000_000,
    parameter int unsigned PERIOD_US     = 10_000,
    parameter int unsigned PERIOD_CYCLES = tick_timer_pkg::us_to_cycles(CLK_FREQ_HZ, PERIOD_US),
    parameter int unsigned CNT_W         = tick_timer_pkg::count_width(PERIOD_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_toggle_i,
    output logic irq_o
);
    logic             toggle_w;
    logic             terminal_w;
    logic             irq_w;
    logic [CNT_W-1:0] count_w;

    tick_ack_detect u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ack_toggle_i),
        .toggle_o (toggle_w)
    );

    tick_period_counter #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .CNT_W         (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (toggle_w),
        .hold_i     (irq_w),
        .count_o    (count_w),
        .terminal_o (terminal_w)
    );

    tick_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (terminal_w),
        .clear_i (toggle_w),
        .irq_o   (irq_w)
    );

    assign irq_o = irq_w;

    // R2: the line only rises from the last count value.
    a_r2_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_w) |-> ($past(count_w) == CNT_W'(PERIOD_CYCLES - 1)))
        else $error("irq rose before period end");
    // R5: while pending the count rests at zero.
    a_r5_pending_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_w |-> (count_w == '0))
        else $error("count moving while pending");
    // R9: a toggle on the final edge keeps the line low.
    a_r9_toggle_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_w && !irq_w) |=> !irq_w)
        else $error("irq set despite toggle");
endmodule

// File: tb/tick_irq_timer_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tick_irq_timer_tb_top;
    localparam int unsigned PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0;
    logic irq;
    int   n_checks = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    tick_irq_timer #(.CLK_FREQ_HZ(1_000_000), .PERIOD_US(PER)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_toggle_i (ack),
        .irq_o        (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq, exp, $time);
        end
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        ack = lvl;
        tick(3);
        rst_n = 1'b1;
    endtask

    // R1 R2: reset state and first period length.
    task automatic t_reset_period();
        do_reset(1'b0);
        check("R1", 1'b0);
        tick(PER - 1); check("R2", 1'b0);
        tick(1);       check("R2", 1'b1);
    endtask

    // R3 R5 R4: long pending, then acknowledge, full period follows.
    task automatic t_pending_ack();
        do_reset(1'b0);
        tick(PER);
        tick(3 * PER); check("R3", 1'b1);
        ack = ~ack;
        tick(1);       check("R4", 1'b0);
        tick(PER - 1); check("R5", 1'b0);
        tick(1);       check("R4", 1'b1);
    endtask

    // R7: falling edge of the toggle also acknowledges.
    task automatic t_both_edges();
        do_reset(1'b1);
        tick(PER);     check("R7", 1'b1);
        ack = 1'b0;
        tick(1);       check("R7", 1'b0);
        tick(PER);     check("R7", 1'b1);
        ack = 1'b1;
        tick(1);       check("R7", 1'b0);
    endtask

    // R6: toggle mid-period restarts the count.
    task automatic t_mid_restart();
        do_reset(1'b0);
        tick(PER / 2);
        ack = ~ack;
        tick(PER);     check("R6", 1'b0);
        tick(1);       check("R6", 1'b1);
    endtask

    // R8: a level held through reset is not a toggle.
    task automatic t_reset_sample();
        do_reset(1'b1);
        tick(PER - 1); check("R8", 1'b0);
        tick(1);       check("R8", 1'b1);
    endtask

    // R9: toggle on the terminal edge wins.
    task automatic t_collide();
        do_reset(1'b0);
        tick(PER - 1);
        ack = ~ack;
        tick(1);       check("R9", 1'b0);
        tick(PER - 1); check("R9", 1'b0);
        tick(1);       check("R9", 1'b1);
    endtask

    // R10: reset while pending clears and restarts.
    task automatic t_reset_pending();
        do_reset(1'b0);
        tick(PER);     check("R10", 1'b1);
        do_reset(1'b0);
        check("R10", 1'b0);
        tick(PER - 1); check("R10", 1'b0);
        tick(1);       check("R10", 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset_period();
                t_pending_ack();
                t_both_edges();
                t_mid_restart();
                t_reset_sample();
                t_collide();
                t_reset_pending();
            end
            begin
                repeat (50_000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run hung, actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule